// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block walks a circular table of receive buffer descriptors for an Ethernet receiver. Software fills descriptors in memory, and the engine takes them in order. Each descriptor is 8 bytes: a control/status word at offset 0 and a buffer address word at offset 4. While reception is enabled, the engine reads the control word of the current descriptor. If the descriptor is armed, the engine then reads its buffer address and presents it to the payload side as the landing buffer for the next frame.

When the receiver reports a finished frame, the engine writes the length and the error flags back into the control word. The same write clears the arm bit, which returns the descriptor to software. The engine then moves on, to the next entry or, if the descriptor carried a wrap mark, to entry zero. A descriptor can ask for an interrupt when it completes. If the engine finds an unarmed descriptor, it turns reception off until software arms that descriptor and enables reception again.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset the control register reads 0, the status register reads only the size code in bits [5:4], `irq` is low, and neither `mem_req` nor `buf_valid` is asserted.
- R2: While reception is enabled (control bit 0), the engine reads the control word at base + 8*index. If bit 11 of that word (arm) is set, it reads the word at base + 8*index + 4 and drives that word on `buf_addr` with `buf_valid` high.
- R3: When a frame completes, the write-back control word holds the length in [10:0], bit 11 cleared, the wrap bit 12 and interrupt bit 13 carried over from the descriptor, and the error flags in [18:14]: too long 14, non-octet 15, CRC 16, overrun 17, length 18. All other bits are 0.
- R4: After a write-back the index increments, or returns to 0 when the descriptor had its wrap bit set.
- R5: Reading an unarmed control word clears control bit 0 and leaves `buf_valid` low. Once software arms that descriptor and sets bit 0 again, the engine resumes at that same descriptor.
- R6: A `frm_done` pulse that arrives while `buf_valid` is low or control bit 0 is clear is dropped and writes no memory.
- R7: The completion of a descriptor whose bit 13 is set raises status bit 0 if the frame had no error flags, or status bit 1 if it had any. The status bits are write-one-to-clear. `irq` is high exactly when control bit 1 is set and a status bit is set.
- R8: The table base register (offset 2) forces to zero its low 10+SIZE_LOG bits, the bits that address inside the table.
- R9: Once `mem_req` is raised it stays high, and its address, direction and write data stay stable, until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 table base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| buf_valid | output | 1 | An armed descriptor is held for the next frame |
| buf_addr | output | 32 | Buffer address of the held descriptor |
| frm_done | input | 1 | One-cycle frame-complete pulse |
| frm_len | input | 11 | Received frame length |
| frm_err | input | 5 | Error flags {length, overrun, CRC, non-octet, too long} |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest state to reach from the ports is the engine that has turned itself off on an unarmed descriptor and must later restart at that same entry, because it occurs only after the ring has wrapped onto a slot software has not re-armed. The bench reaches it deliberately: it completes frames through a three-entry ring with a wrap mark, then leaves entry zero unarmed. It then checks that the enable bit drops, that a frame arriving meanwhile is lost, and that the resumed buffer is entry zero. After that, a four-entry ring with random lengths, random error mixes and a memory responder with random latency exercises write-back and status under varied timing.

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
  parameter int SIZE_LOG = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        buf_valid,
  output logic [31:0] buf_addr,
  input  logic        frm_done,
  input  logic [10:0] frm_len,
  input  logic [4:0]  frm_err,
  output logic        irq
);
  localparam int IW = 7 + SIZE_LOG;
  localparam int AL = IW + 3;
  localparam logic [1:0] SIZE_CODE = 2'(SIZE_LOG);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_ARM, S_WB} st_t;

  st_t            state;
  logic           rx_en, irq_en, st_ok, st_err;
  logic [31-AL:0] base;
  logic [IW-1:0]  idx;
  logic           d_wrap, d_irq;
  logic [31:0]    buf_q;
  logic [10:0]    len_q;
  logic [4:0]     err_q;

  wire take   = (state == S_ARM) && rx_en && frm_done;
  wire wb_end = (state == S_WB) && mem_ack;
  wire clr_wr = reg_wr && (reg_addr == 2'd1);

  assign mem_req   = (state == S_CTRL) || (state == S_ADDR) || (state == S_WB);
  assign mem_we    = (state == S_WB);
  assign mem_addr  = {base, idx, (state == S_ADDR), 2'b00};
  assign mem_wdata = {13'b0, err_q, d_irq, d_wrap, 1'b0, len_q};
  assign buf_valid = (state == S_ARM);
  assign buf_addr  = buf_q;
  assign irq       = irq_en && (st_ok || st_err);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {30'b0, irq_en, rx_en};
      2'd1:    reg_rdata = {26'b0, SIZE_CODE, 2'b00, st_err, st_ok};
      2'd2:    reg_rdata = {base, {AL{1'b0}}};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rx_en  <= 1'b0;
      irq_en <= 1'b0;
      st_ok  <= 1'b0;
      st_err <= 1'b0;
      base   <= '0;
      idx    <= '0;
      d_wrap <= 1'b0;
      d_irq  <= 1'b0;
      buf_q  <= '0;
      len_q  <= '0;
      err_q  <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) begin
        rx_en  <= reg_wdata[0];
        irq_en <= reg_wdata[1];
      end else if (state == S_CTRL && mem_ack && !mem_rdata[11]) begin
        rx_en <= 1'b0;
      end
      if (reg_wr && reg_addr == 2'd2)
        base <= reg_wdata[31:AL];

      st_ok  <= (wb_end && d_irq && err_q == 5'd0) || (st_ok  && !(clr_wr && reg_wdata[0]));
      st_err <= (wb_end && d_irq && err_q != 5'd0) || (st_err && !(clr_wr && reg_wdata[1]));

      case (state)
        S_IDLE: if (rx_en) state <= S_CTRL;
        S_CTRL: if (mem_ack) begin
          d_wrap <= mem_rdata[12];
          d_irq  <= mem_rdata[13];
          state  <= mem_rdata[11] ? S_ADDR : S_IDLE;
        end
        S_ADDR: if (mem_ack) begin
          buf_q <= mem_rdata;
          state <= S_ARM;
        end
        S_ARM: if (take) begin
          len_q <= frm_len;
          err_q <= frm_err;
          state <= S_WB;
        end
        S_WB: if (mem_ack) begin
          idx   <= d_wrap ? '0 : idx + 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_desc_ring_chk.sv
module rx_desc_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        buf_valid,
  input logic        frm_done,
  input logic        rx_en,
  input logic        irq_en,
  input logic        irq
);
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r3_wb_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[11] && mem_wdata[31:19] == 13'b0);

  a_r3_wb_ctrl_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_addr[2]);

  a_r6_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && (!buf_valid || !rx_en) && !(mem_req && mem_we) |=> !(mem_req && mem_we));

  a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> !mem_req);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
endmodule

bind rx_desc_ring rx_desc_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .buf_valid(buf_valid),
  .frm_done(frm_done), .rx_en(rx_en), .irq_en(irq_en), .irq(irq)
);

// File: tb/tb_rx_desc_ring.sv
module tb_rx_desc_ring;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        buf_valid, irq;
  logic [31:0] buf_addr;
  logic        frm_done = 0;
  logic [10:0] frm_len = 0;
  logic [4:0]  frm_err = 0;

  int checks = 0, errors = 0;
  logic [31:0] mem [0:4095];
  logic        sw_we = 0;
  logic [11:0] sw_a = 0;
  logic [31:0] sw_d = 0;

  localparam logic [31:0] BASE = 32'h0000_2400;
  localparam int BW = 12'h900;

  always #2.5 clk = ~clk;

  rx_desc_ring dut (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      if (sw_we) mem[sw_a] <= sw_d;
      if (mem_req && !mem_ack && ($urandom % 4 != 0)) begin
        mem_ack <= 1'b1;
        mem_rdata <= mem[mem_addr[13:2]];
        if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      end else mem_ack <= 1'b0;
    end
  end

  function automatic logic [31:0] cw(input bit wrap, input bit ie);
    return 32'h800 | (32'(wrap) << 12) | (32'(ie) << 13);
  endfunction
  function automatic logic [31:0] exp_wb(input logic [31:0] c, input logic [10:0] len, input logic [4:0] err);
    return {13'b0, err, c[13], c[12], 1'b0, len};
  endfunction
  function automatic logic [31:0] bufa(input int i);
    return 32'hB000_0000 + 32'(i) * 32'h800;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic poke(input int w, input logic [31:0] d);
    @(negedge clk); sw_we = 1; sw_a = 12'(w); sw_d = d;
    @(negedge clk); sw_we = 0;
  endtask

  task automatic arm(input int i, input logic [31:0] c);
    poke(BW + 2*i + 1, bufa(i));
    poke(BW + 2*i, c);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #0.1; d = reg_rdata;
  endtask

  task automatic wait_valid(input string req);
    int n = 0;
    @(negedge clk);
    while (!buf_valid && n < 200) begin @(negedge clk); n++; end
    check(req, 32'(buf_valid), 32'd1);
  endtask

  task automatic frame(input logic [10:0] len, input logic [4:0] err);
    @(negedge clk); frm_done = 1; frm_len = len; frm_err = err;
    @(negedge clk); frm_done = 0;
  endtask

  task automatic wait_wb(input int i);
    int n = 0;
    while (mem[BW + 2*i][11] && n < 200) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] r;
    logic [31:0] c [4];
    int cur;
    void'($urandom(32'd2024));
    for (int k = 0; k < 4096; k++) mem[k] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rreg(2'd0, r); check("R1 ctrl", r, 32'h0);
    rreg(2'd1, r); check("R1 status", r, 32'h0);
    check("R1 irq", 32'(irq), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 buf_valid", 32'(buf_valid), 0);

    // R8 base alignment
    wreg(2'd2, BASE | 32'h3FF);
    rreg(2'd2, r); check("R8 base aligned", r, BASE);

    arm(0, cw(0, 1)); arm(1, cw(0, 0)); arm(2, cw(1, 1));
    wreg(2'd0, 32'h1);

    // R2 fetch and present buffer
    wait_valid("R2 valid d0");
    check("R2 buf d0", buf_addr, bufa(0));
    frame(11'd64, 5'd0);
    wait_wb(0);
    check("R3 wb d0", mem[BW], exp_wb(cw(0, 1), 11'd64, 5'd0));
    rreg(2'd1, r); check("R7 status ok", r, 32'h1);
    check("R7 irq gated off", 32'(irq), 0);
    wreg(2'd0, 32'h3);
    check("R7 irq on", 32'(irq), 1);
    wreg(2'd1, 32'h1);
    rreg(2'd1, r); check("R7 w1c", r, 32'h0);
    check("R7 irq cleared", 32'(irq), 0);

    // R4 increment, no irq descriptor
    wait_valid("R4 valid d1");
    check("R4 buf d1", buf_addr, bufa(1));
    frame(11'd300, 5'b00100);
    wait_wb(1);
    check("R3 wb d1 crc", mem[BW + 2], exp_wb(cw(0, 0), 11'd300, 5'b00100));
    rreg(2'd1, r); check("R7 no irq bit", r, 32'h0);

    wait_valid("R4 valid d2");
    frame(11'd1518, 5'b00001);
    wait_wb(2);
    check("R3 wb d2 long", mem[BW + 4], exp_wb(cw(1, 1), 11'd1518, 5'b00001));
    rreg(2'd1, r); check("R7 err status", r, 32'h2);
    check("R7 irq err", 32'(irq), 1);
    wreg(2'd1, 32'h2);

    // R5 wrap lands on disarmed d0
    repeat (10) @(negedge clk);
    rreg(2'd0, r); check("R5 rx_en cleared", r, 32'h2);
    check("R5 no buffer", 32'(buf_valid), 0);
    r = mem[BW];
    frame(11'd99, 5'd0);
    repeat (10) @(negedge clk);
    check("R6 drop while off", mem[BW], r);
    arm(0, cw(0, 1)); arm(1, cw(0, 1)); arm(2, cw(0, 0)); arm(3, cw(1, 1));
    wreg(2'd0, 32'h3);
    wait_valid("R5 resume");
    check("R4 wrap to d0", buf_addr, bufa(0));
    frame(11'd128, 5'b10010);
    wait_wb(0);
    check("R3 wb d0 again", mem[BW], exp_wb(cw(0, 1), 11'd128, 5'b10010));
    wreg(2'd1, 32'h3);

    // R6 drop while held but disabled
    wait_valid("R6 hold d1");
    wreg(2'd0, 32'h2);
    frame(11'd77, 5'd0);
    repeat (10) @(negedge clk);
    check("R6 no wb", mem[BW + 2], cw(0, 1));
    wreg(2'd0, 32'h3);

    // Random ring of four
    c[0] = cw(0, 1); c[1] = cw(0, 1); c[2] = cw(0, 0); c[3] = cw(1, 1);
    arm(0, c[0]);
    cur = 1;
    for (int it = 0; it < 40; it++) begin
      logic [10:0] ln;
      logic [4:0]  er;
      logic [31:0] es;
      ln = 11'($urandom);
      er = ($urandom % 3 == 0) ? 5'($urandom) : 5'd0;
      wait_valid("R2 rand valid");
      check("R4 rand buf", buf_addr, bufa(cur));
      frame(ln, er);
      wait_wb(cur);
      check("R3 rand wb", mem[BW + 2*cur], exp_wb(c[cur], ln, er));
      es = c[cur][13] ? ((er != 0) ? 32'h2 : 32'h1) : 32'h0;
      rreg(2'd1, r); check("R7 rand status", r, es);
      check("R7 rand irq", 32'(irq), 32'(es != 0));
      wreg(2'd1, 32'h3);
      arm(cur, c[cur]);
      cur = (cur == 3) ? 0 : cur + 1;
    end
    summary();
  end
endmodule